// File: doc/BRIEF.md
# CEC Line Receiver with Logical Address Filter

This block listens to a single-wire, open-drain consumer-electronics control line and turns the pulse train on it into bytes. A programmable clock divider produces a time base tick (nominally 50 µs). Every duration below is counted in these ticks. The line passes through a two-flop synchronizer and then, when enabled, a stability filter. A state machine then recognises the start bit, measures each data bit against fixed and programmable windows, and decodes its value at the sample point.

Each block on the line carries eight data bits (most significant first), an end-of-message bit and an acknowledge slot. The low nibble of the first byte is the destination address. A 16-bit table holds one enable bit per logical address. A message is kept when its destination bit is set in the table, or when the destination is the broadcast address 15. Only a directed message that is kept is acknowledged, by pulling the line low during the acknowledge slot. Kept bytes go into a 16-entry receive array, which exposes a byte count and an overrun flag.

Events and timing errors set sticky status bits. Each bit is cleared by writing 1 to its position. An interrupt output is the OR of the status bits that are enabled.

Top module: `cec_rx`

## Requirements
- R1: A low pulse of 70..78 ticks, followed by a falling edge 86 ticks or more after the start edge, is a valid start bit and sets status bit 0 (start-of-message).
- R2: Each data bit is decoded from the filtered line level 21 ticks after its falling edge (low is 0, high is 1). Kept bytes are readable in arrival order at `rd_idx_i` 0, 1, 2, and so on.
- R3: In every acknowledge slot of a kept directed message, the block pulls `cec_pull_o` high (line low) for 30 ticks from the slot's falling edge. It does not pull for broadcast (destination 15), for a destination whose table bit is clear, or for any message when the table is zero.
- R4: A message whose destination is neither 15 nor enabled in the table stores no byte and does not set done. Its start bit still sets status bit 0.
- R5: An end-of-message bit of 1 in a kept message sets status bit 1. Its acknowledge sample point then sets status bit 2 (done) and freezes the byte count and array contents until `arr_clr_i`.
- R6: When a kept byte arrives with 16 bytes already stored, the byte is dropped, `rx_cnt_o` stays 16 and `rx_ovr_o` is set. `arr_clr_i` clears both.
- R7: A low pulse shorter than `lpulse_min_i` ticks sets status bit 3. A high pulse shorter than `hpulse_min_i` ticks sets status bit 4. Either error abandons the frame.
- R8: A bit period (falling to falling edge) below 41 ticks, or a start low below 70 ticks, sets status bit 7. A data bit period above 55 ticks, or a start low above 78 ticks, sets status bit 8. Either error abandons the frame.
- R9: No falling edge within 90+2*`sbit_sel_i` ticks of the start edge sets status bit 5. No edge within 52+2*`dbit_sel_i` ticks of a data bit's falling edge sets status bit 6.
- R10: Status bits stay set until a write with `sts_clr_i` high clears the bits set in `sts_clr_mask_i`. Bits outside the mask are unchanged. `irq_o` is the OR of `sts_o & irq_en_i`.
- R11: With `filt_en_i` high, a line pulse shorter than 4 clock cycles is ignored. With the filter off, the same pulse reaches the decoder.
- R12: After reset, `sts_o`, `irq_o`, `rx_cnt_o`, `rx_ovr_o` and `cec_pull_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cec_i | input | 1 | Sensed line level |
| cec_pull_o | output | 1 | 1 pulls the line low |
| filt_en_i | input | 1 | Enable the input stability filter |
| tick_div_i | input | 16 | Clock cycles per time base tick |
| addr_table_i | input | 16 | One acceptance bit per logical address |
| sbit_sel_i | input | 3 | Start bit timeout select |
| dbit_sel_i | input | 3 | Data bit timeout select |
| lpulse_min_i | input | 4 | Minimum low pulse, ticks |
| hpulse_min_i | input | 4 | Minimum high pulse, ticks |
| irq_en_i | input | 9 | Interrupt enable per status bit |
| sts_clr_i | input | 1 | Status clear strobe |
| sts_clr_mask_i | input | 9 | Status bits to clear |
| sts_o | output | 9 | Sticky status bits |
| irq_o | output | 1 | Interrupt request |
| arr_clr_i | input | 1 | Clear the receive array, count, overrun and freeze |
| rd_idx_i | input | 4 | Receive array read index |
| rd_data_o | output | 8 | Receive array byte at rd_idx_i |
| rx_cnt_o | output | 5 | Number of stored bytes |
| rx_ovr_o | output | 1 | Overrun flag |

## Verification
Assertions check, on every cycle, several invariants. Decoder events are mutually exclusive. Every event lands in the status word. The line is only pulled in an acknowledge slot of a kept directed message. The byte count never exceeds the depth, and it holds still while frozen. Overrun only rises at a full array. The bench scenarios are needed for everything tied to the line: decoded byte values, which addresses draw an acknowledge, the frozen array after a second message, filtering of a short glitch, and whether each timing error or timeout flag appears, with the right flag, at the intended pulse lengths.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic [2:0] {S_IDLE, S_ST_LOW, S_ST_HIGH, S_BIT_LOW, S_BIT_HIGH} rx_state_e;

  localparam int unsigned EV_W      = 9;
  localparam int unsigned EV_SOM    = 0;
  localparam int unsigned EV_EOM    = 1;
  localparam int unsigned EV_DONE   = 2;
  localparam int unsigned EV_LPULSE = 3;
  localparam int unsigned EV_HPULSE = 4;
  localparam int unsigned EV_STOUT  = 5;
  localparam int unsigned EV_DTOUT  = 6;
  localparam int unsigned EV_MIN    = 7;
  localparam int unsigned EV_MAX    = 8;

  // durations in time base ticks
  localparam logic [7:0] T_SAMPLE      = 8'd21;
  localparam logic [7:0] T_ACK         = 8'd30;
  localparam logic [7:0] T_ST_LOW_MIN  = 8'd70;
  localparam logic [7:0] T_ST_LOW_MAX  = 8'd78;
  localparam logic [7:0] T_ST_PER_MIN  = 8'd86;
  localparam logic [7:0] T_ST_TOUT     = 8'd90;
  localparam logic [7:0] T_BIT_MIN     = 8'd41;
  localparam logic [7:0] T_BIT_MAX     = 8'd55;
  localparam logic [7:0] T_D_TOUT      = 8'd52;
  localparam logic [3:0] ADDR_BCAST    = 4'hF;
endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic [DIV_W:0]   nxt;

  assign nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (nxt >= {1'b0, div_i}) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= nxt[DIV_W-1:0];
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/cec_line_filter.sv
module cec_line_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic filt_en_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic          sync1_q, sync2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      filt_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      if (sync2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= sync2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = filt_en_i ? filt_q : sync2_q;
endmodule

// File: rtl/cec_rx_fsm.sv
module cec_rx_fsm
  import cec_rx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            line_i,
  input  logic [15:0]     addr_table_i,
  input  logic [2:0]      sbit_sel_i,
  input  logic [2:0]      dbit_sel_i,
  input  logic [3:0]      lpulse_min_i,
  input  logic [3:0]      hpulse_min_i,
  output logic [EV_W-1:0] ev_o,
  output logic            wr_o,
  output logic [7:0]      wr_data_o,
  output logic            pull_o
);
  rx_state_e       state_q;
  logic [7:0]      cnt_q, rise_q, pull_cnt_q, wr_data_q;
  logic [3:0]      bit_idx_q;
  logic [6:0]      shift_q;
  logic            line_d, samp_q, hdr_q, acc_q, dir_q, eom_q, pull_q, wr_q;
  logic [EV_W-1:0] ev_q;

  logic       fall, rise, hit;
  logic [7:0] st_tout, dt_tout, lp_min, hp_min, hi_len;
  logic [7:0] byte_v;

  assign fall    = line_d & ~line_i;
  assign rise    = ~line_d & line_i;
  assign st_tout = T_ST_TOUT + {4'b0, sbit_sel_i, 1'b0};
  assign dt_tout = T_D_TOUT + {4'b0, dbit_sel_i, 1'b0};
  assign lp_min  = {4'b0, lpulse_min_i};
  assign hp_min  = {4'b0, hpulse_min_i};
  assign hi_len  = cnt_q - rise_q;
  assign byte_v  = {shift_q, line_i};
  assign hit     = (byte_v[3:0] == ADDR_BCAST) || addr_table_i[byte_v[3:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      rise_q     <= '0;
      pull_cnt_q <= '0;
      wr_data_q  <= '0;
      bit_idx_q  <= '0;
      shift_q    <= '0;
      line_d     <= 1'b1;
      samp_q     <= 1'b0;
      hdr_q      <= 1'b0;
      acc_q      <= 1'b0;
      dir_q      <= 1'b0;
      eom_q      <= 1'b0;
      pull_q     <= 1'b0;
      wr_q       <= 1'b0;
      ev_q       <= '0;
    end else begin
      ev_q   <= '0;
      wr_q   <= 1'b0;
      line_d <= line_i;
      if (tick_i && cnt_q != 8'hFF) cnt_q <= cnt_q + 1'b1;
      if (pull_q && tick_i) begin
        if (pull_cnt_q == T_ACK - 1'b1) pull_q <= 1'b0;
        else pull_cnt_q <= pull_cnt_q + 1'b1;
      end
      unique case (state_q)
        S_IDLE: begin
          if (fall) begin
            state_q <= S_ST_LOW;
            cnt_q   <= '0;
          end
        end
        S_ST_LOW: begin
          if (rise) begin
            rise_q <= cnt_q;
            if (cnt_q < lp_min) begin
              ev_q[EV_LPULSE] <= 1'b1;
              state_q         <= S_IDLE;
            end else if (cnt_q < T_ST_LOW_MIN) begin
              ev_q[EV_MIN] <= 1'b1;
              state_q      <= S_IDLE;
            end else begin
              state_q <= S_ST_HIGH;
            end
          end else if (cnt_q > T_ST_LOW_MAX) begin
            ev_q[EV_MAX] <= 1'b1;
            state_q      <= S_IDLE;
          end
        end
        S_ST_HIGH: begin
          if (fall) begin
            if (hi_len < hp_min) begin
              ev_q[EV_HPULSE] <= 1'b1;
              state_q         <= S_IDLE;
            end else if (cnt_q < T_ST_PER_MIN) begin
              ev_q[EV_MIN] <= 1'b1;
              state_q      <= S_IDLE;
            end else begin
              ev_q[EV_SOM] <= 1'b1;
              state_q      <= S_BIT_LOW;
              cnt_q        <= '0;
              samp_q       <= 1'b0;
              bit_idx_q    <= '0;
              hdr_q        <= 1'b1;
              acc_q        <= 1'b0;
              dir_q        <= 1'b0;
              eom_q        <= 1'b0;
            end
          end else if (cnt_q >= st_tout) begin
            ev_q[EV_STOUT] <= 1'b1;
            state_q        <= S_IDLE;
          end
        end
        S_BIT_LOW, S_BIT_HIGH: begin
          if (state_q == S_BIT_LOW && rise) begin
            rise_q <= cnt_q;
            if (cnt_q < lp_min) begin
              ev_q[EV_LPULSE] <= 1'b1;
              state_q         <= S_IDLE;
            end else begin
              state_q <= S_BIT_HIGH;
            end
          end else if (state_q == S_BIT_HIGH && fall) begin
            if (hi_len < hp_min) begin
              ev_q[EV_HPULSE] <= 1'b1;
              state_q         <= S_IDLE;
            end else if (cnt_q < T_BIT_MIN) begin
              ev_q[EV_MIN] <= 1'b1;
              state_q      <= S_IDLE;
            end else if (cnt_q > T_BIT_MAX) begin
              ev_q[EV_MAX] <= 1'b1;
              state_q      <= S_IDLE;
            end else begin
              state_q   <= S_BIT_LOW;
              cnt_q     <= '0;
              samp_q    <= 1'b0;
              bit_idx_q <= (bit_idx_q == 4'd9) ? 4'd0 : bit_idx_q + 1'b1;
              if (bit_idx_q == 4'd8 && acc_q && dir_q) begin
                pull_q     <= 1'b1;
                pull_cnt_q <= '0;
              end
            end
          end else if (cnt_q >= dt_tout) begin
            ev_q[EV_DTOUT] <= 1'b1;
            state_q        <= S_IDLE;
          end else if (!samp_q && cnt_q >= T_SAMPLE) begin
            samp_q <= 1'b1;
            if (bit_idx_q < 4'd8) begin
              shift_q <= byte_v[6:0];
              if (bit_idx_q == 4'd7) begin
                hdr_q     <= 1'b0;
                wr_data_q <= byte_v;
                if (hdr_q) begin
                  acc_q <= hit;
                  dir_q <= (byte_v[3:0] != ADDR_BCAST);
                  wr_q  <= hit;
                end else begin
                  wr_q <= acc_q;
                end
              end
            end else if (bit_idx_q == 4'd8) begin
              eom_q <= line_i;
              if (line_i && acc_q) ev_q[EV_EOM] <= 1'b1;
            end else if (eom_q) begin
              if (acc_q) ev_q[EV_DONE] <= 1'b1;
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ev_o      = ev_q;
  assign wr_o      = wr_q;
  assign wr_data_o = wr_data_q;
  assign pull_o    = pull_q;

  AST_EV_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_q)); // R8
  AST_PULL_DIRECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> (acc_q && dir_q && bit_idx_q == 4'd9)); // R3
  AST_WR_IN_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> (bit_idx_q == 4'd7 && acc_q)); // R4
endmodule

// File: rtl/cec_rx_array.sv
module cec_rx_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             done_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovr_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q, frz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
      frz_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
      frz_q <= 1'b0;
    end else begin
      if (done_i) frz_q <= 1'b1;
      if (wr_i && !frz_q) begin
        if (cnt_q == CNT_W'(DEPTH)) begin
          ovr_q <= 1'b1;
        end else begin
          mem_q[cnt_q[IDX_W-1:0]] <= wr_data_i;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign cnt_o     = cnt_q;
  assign ovr_o     = ovr_q;

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R6
  AST_OVR_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> cnt_q == CNT_W'(DEPTH)); // R6
  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && !clr_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/cec_rx.sv
module cec_rx
  import cec_rx_pkg::*;
#(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned FILT_LEN = 4,
  parameter int unsigned DEPTH    = 16,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cec_i,
  output logic             cec_pull_o,
  input  logic             filt_en_i,
  input  logic [DIV_W-1:0] tick_div_i,
  input  logic [15:0]      addr_table_i,
  input  logic [2:0]       sbit_sel_i,
  input  logic [2:0]       dbit_sel_i,
  input  logic [3:0]       lpulse_min_i,
  input  logic [3:0]       hpulse_min_i,
  input  logic [EV_W-1:0]  irq_en_i,
  input  logic             sts_clr_i,
  input  logic [EV_W-1:0]  sts_clr_mask_i,
  output logic [EV_W-1:0]  sts_o,
  output logic             irq_o,
  input  logic             arr_clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic [CNT_W-1:0] rx_cnt_o,
  output logic             rx_ovr_o
);
  logic            tick, line_f, wr;
  logic [7:0]      wr_data;
  logic [EV_W-1:0] ev, sts_q, clr_m;

  cec_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i(tick_div_i), .tick_o(tick)
  );

  cec_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i, .rst_ni, .line_i(cec_i), .filt_en_i, .line_o(line_f)
  );

  cec_rx_fsm u_fsm (
    .clk_i, .rst_ni, .tick_i(tick), .line_i(line_f), .addr_table_i,
    .sbit_sel_i, .dbit_sel_i, .lpulse_min_i, .hpulse_min_i,
    .ev_o(ev), .wr_o(wr), .wr_data_o(wr_data), .pull_o(cec_pull_o)
  );

  cec_rx_array #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_arr (
    .clk_i, .rst_ni, .wr_i(wr), .wr_data_i(wr_data), .done_i(ev[EV_DONE]),
    .clr_i(arr_clr_i), .rd_idx_i, .rd_data_o, .cnt_o(rx_cnt_o), .ovr_o(rx_ovr_o)
  );

  assign clr_m = sts_clr_i ? sts_clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_m) | ev;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & irq_en_i);

  AST_EVENT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((sts_q & $past(ev)) == $past(ev))); // R10
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_clr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R10
endmodule

// File: tb/sim_cec_rx.sv
`timescale 1ns/1ps
module sim_cec_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drv_low = 1'b0;
  logic        cec_pull, filt_en = 1'b0, sts_clr = 1'b0, arr_clr = 1'b0, irq, ovr;
  logic [15:0] div = 16'd4, table_v = 16'h0010;
  logic [2:0]  ssel = 3'd2, dsel = 3'd2;
  logic [3:0]  lmin = 4'd6, hmin = 4'd6, rd_idx = '0;
  logic [8:0]  irq_en = 9'h004, clr_mask = '0, sts;
  logic [7:0]  rd_data;
  logic [4:0]  cnt;
  wire         cec_line = ~(drv_low | cec_pull);

  int n_chk = 0, n_fail = 0;
  logic [7:0]  tx_buf [20];
  logic [19:0] acks;
  bit          finished = 0;

  always #5 clk = ~clk;

  cec_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .cec_i(cec_line), .cec_pull_o(cec_pull),
    .filt_en_i(filt_en), .tick_div_i(div), .addr_table_i(table_v),
    .sbit_sel_i(ssel), .dbit_sel_i(dsel), .lpulse_min_i(lmin), .hpulse_min_i(hmin),
    .irq_en_i(irq_en), .sts_clr_i(sts_clr), .sts_clr_mask_i(clr_mask),
    .sts_o(sts), .irq_o(irq), .arr_clr_i(arr_clr), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .rx_cnt_o(cnt), .rx_ovr_o(ovr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int ticks);
    repeat (ticks * 4) @(negedge clk);
  endtask

  task automatic lowhigh(input int lo, input int hi);
    drv_low = 1'b1; wt(lo);
    drv_low = 1'b0; wt(hi);
  endtask

  task automatic send_bit(input logic b);
    if (b) lowhigh(12, 36); else lowhigh(30, 18);
  endtask

  task automatic send_msg(input int n);
    acks = '0;
    lowhigh(74, 16);
    for (int k = 0; k < n; k++) begin
      for (int j = 7; j >= 0; j--) send_bit(tx_buf[k][j]);
      send_bit(k == n - 1);
      drv_low = 1'b1; wt(12);
      drv_low = 1'b0; wt(8);
      acks[k] = ~cec_line;
      wt(28);
    end
    wt(20);
  endtask

  task automatic clear_all();
    @(negedge clk);
    arr_clr = 1'b1; sts_clr = 1'b1; clr_mask = 9'h1FF;
    @(negedge clk);
    arr_clr = 1'b0; sts_clr = 1'b0; clr_mask = '0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input int idx, input int exp);
    rd_idx = idx[3:0];
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R12 sts", sts, 0);
    chk("R12 irq", irq, 0);
    chk("R12 cnt", cnt, 0);
    chk("R12 ovr", ovr, 0);
    chk("R12 pull", cec_pull, 0);
  endtask

  task automatic t_directed();
    table_v = 16'h0010;
    tx_buf[0] = 8'h04; tx_buf[1] = 8'hA5; tx_buf[2] = 8'h3C;
    send_msg(3);
    chk("R1 som", sts[0], 1);
    chk("R5 eom", sts[1], 1);
    chk("R5 done", sts[2], 1);
    chk("R2 cnt", cnt, 3);
    rd_chk("R2 byte0", 0, 8'h04);
    rd_chk("R2 byte1", 1, 8'hA5);
    rd_chk("R2 byte2", 2, 8'h3C);
    chk("R3 acks", acks[2:0], 3'b111);
    chk("R10 irq on done", irq, 1);
    @(negedge clk); sts_clr = 1'b1; clr_mask = 9'h004;
    @(negedge clk); sts_clr = 1'b0; clr_mask = '0;
    @(negedge clk);
    chk("R10 cleared bit", sts[2], 0);
    chk("R10 other bits kept", sts[1:0], 2'b11);
    chk("R10 irq off", irq, 0);
  endtask

  task automatic t_frozen();
    tx_buf[0] = 8'h04; tx_buf[1] = 8'h77;
    send_msg(2);
    chk("R5 frozen cnt", cnt, 3);
    rd_chk("R5 frozen byte1", 1, 8'hA5);
    clear_all();
  endtask

  task automatic t_broadcast();
    tx_buf[0] = 8'h3F; tx_buf[1] = 8'h55;
    send_msg(2);
    chk("R3 no ack bcast", acks[1:0], 0);
    chk("R2 bcast cnt", cnt, 2);
    rd_chk("R2 bcast byte1", 1, 8'h55);
    chk("R5 bcast done", sts[2], 1);
    clear_all();
  endtask

  task automatic t_miss();
    tx_buf[0] = 8'h07; tx_buf[1] = 8'h11;
    send_msg(2);
    chk("R4 miss cnt", cnt, 0);
    chk("R4 miss done", sts[2], 0);
    chk("R4 miss som", sts[0], 1);
    chk("R3 miss ack", acks[1:0], 0);
    clear_all();
    table_v = 16'h0000;
    tx_buf[0] = 8'h04;
    send_msg(1);
    chk("R3 empty table ack", acks[0], 0);
    chk("R4 empty table cnt", cnt, 0);
    table_v = 16'h0010;
    clear_all();
  endtask

  task automatic t_overrun();
    tx_buf[0] = 8'h04;
    for (int k = 1; k < 17; k++) tx_buf[k] = 8'h10 + k[7:0];
    send_msg(17);
    chk("R6 cnt sat", cnt, 16);
    chk("R6 ovr", ovr, 1);
    rd_chk("R6 last kept", 15, 8'h1F);
    clear_all();
    chk("R6 clr ovr", ovr, 0);
    chk("R6 clr cnt", cnt, 0);
  endtask

  task automatic t_filter();
    filt_en = 1'b1;
    @(negedge clk); drv_low = 1'b1;
    repeat (2) @(negedge clk); drv_low = 1'b0;
    wt(20);
    chk("R11 glitch filtered", sts, 0);
    filt_en = 1'b0;
    @(negedge clk); drv_low = 1'b1;
    repeat (2) @(negedge clk); drv_low = 1'b0;
    wt(20);
    chk("R11 glitch unfiltered R7", sts, 9'h008);
    clear_all();
  endtask

  task automatic t_pulse_err();
    lowhigh(74, 16); lowhigh(3, 60);
    chk("R7 low pulse", sts, 9'h009);
    clear_all();
    lowhigh(74, 16); lowhigh(30, 2); lowhigh(10, 60);
    chk("R7 high pulse", sts, 9'h011);
    clear_all();
  endtask

  task automatic t_period_err();
    lowhigh(74, 16); lowhigh(12, 20); lowhigh(12, 60);
    chk("R8 short bit", sts, 9'h081);
    clear_all();
    lowhigh(60, 60);
    chk("R8 short start", sts, 9'h080);
    clear_all();
    dsel = 3'd7;
    lowhigh(74, 16); lowhigh(12, 48); lowhigh(12, 60);
    chk("R8 long bit", sts, 9'h101);
    dsel = 3'd2;
    clear_all();
  endtask

  task automatic t_timeout();
    lowhigh(74, 16); lowhigh(12, 38);
    chk("R9 data tout early", sts[6], 0);
    wt(20);
    chk("R9 data tout", sts, 9'h041);
    clear_all();
    drv_low = 1'b1; wt(74); drv_low = 1'b0; wt(16);
    chk("R9 start tout early", sts[5], 0);
    wt(8);
    chk("R9 start tout", sts, 9'h020);
    clear_all();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_directed();
    t_frozen();
    t_broadcast();
    t_miss();
    t_overrun();
    t_filter();
    t_pulse_err();
    t_period_err();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule